// File: doc/BRIEF.md
# Table-Driven Serial Clock Divider

This block derives the serial-interface clock from a fast reference clock. The reference nominally runs at 800 MHz. A 4-bit code picks one divisor from a fixed, non-uniform table of even values. The available rates run from 200 MHz (code 0) down to 6.25 MHz (code 13). After setup, software normally selects code 9, which divides by 32 and gives 25 MHz. Because every divisor is even, the output toggles every divisor/2 reference cycles and keeps an exact 50% duty cycle.

A small control word holds three fields: the run enable, the divider code and an interrupt-enable flag. The control word can be written and read back. The code only takes effect while the clock is stopped. To change the rate, software writes the word with the enable cleared, then writes the new code with enable (and interrupt enable) set. A code written while the clock runs is stored and shown on read-back, but the running clock keeps its old divisor until the next stopped period. The output therefore never produces a short or stretched pulse during a rate change.

Top module: `sclk_divider`

## Requirements
- R1: A synchronous active-low reset clears the control word: read-back is 0, the output clock is low and the interrupt-enable output is 0.
- R2: Control-word layout: bit 0 is run enable, bits 4:1 are the divider code, bit 6 is interrupt enable. Read-back returns these fields as written, and every other bit reads 0.
- R3: Codes 0 to 13 select the divisors 4, 6, 8, 10, 12, 16, 18, 20, 24, 32, 40, 50, 64 and 128, in that order.
- R4: Codes 14 and 15 are reserved and divide by 128.
- R5: While running, the output is high for exactly divisor/2 reference cycles, then low for exactly divisor/2 reference cycles.
- R6: While the enable bit is 0, the output clock is held low.
- R7: The first high phase is full width. The output rises on the second reference edge after the write that sets enable, then stays high for divisor/2 cycles.
- R8: A code written while the clock runs does not change the running divisor, but read-back shows the written code.
- R9: The interrupt-enable output follows control bit 6.
- R10: The sequence disable, then write the new code with enable set, restarts the clock at the new divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control-word write value |
| rd_data | output | 32 | Control-word read-back |
| irq_en_o | output | 1 | Interrupt-enable flag |
| sclk_o | output | 1 | Divided serial clock |

## Verification
The bench walks all sixteen codes, including the two reserved ones, and measures each high and low phase in reference cycles. A wrong table entry, a missing fallback for the reserved codes, or an off-by-one terminal count shows up as a wrong phase length or an uneven duty cycle. It rewrites the code while the clock is running and checks that the period stays the same. A design that let the new code through at once would change the period mid-stream, which is the glitch this block exists to prevent. It also checks the rise latency after enable and that the output stays low while stopped. A counter that is not cleared on disable would give a short first pulse or a wrong edge position.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int CTRL_W   = 32;
  localparam int CODE_W   = 4;
  localparam int DIV_W    = 8;
  localparam int HALF_W   = DIV_W - 1;
  localparam int NCODES   = 1 << CODE_W;
  localparam int EN_BIT   = 0;
  localparam int CODE_LSB = 1;
  localparam int IRQ_BIT  = 6;

  localparam logic [CTRL_W-1:0] CTRL_MASK =
    (CTRL_W'(1) << EN_BIT) | (CTRL_W'(NCODES - 1) << CODE_LSB) | (CTRL_W'(1) << IRQ_BIT);

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [DIV_W-1:0]  div_t;
  typedef logic [HALF_W-1:0] half_t;

  // Divisor for a code; reserved codes fall back to the slowest rate.
  function automatic div_t code_to_div(input code_t c);
    case (c)
      4'd0:    return div_t'(4);
      4'd1:    return div_t'(6);
      4'd2:    return div_t'(8);
      4'd3:    return div_t'(10);
      4'd4:    return div_t'(12);
      4'd5:    return div_t'(16);
      4'd6:    return div_t'(18);
      4'd7:    return div_t'(20);
      4'd8:    return div_t'(24);
      4'd9:    return div_t'(32);
      4'd10:   return div_t'(40);
      4'd11:   return div_t'(50);
      4'd12:   return div_t'(64);
      default: return div_t'(128);
    endcase
  endfunction

  // Terminal count of one half period.
  function automatic half_t half_minus_one(input div_t d);
    return half_t'(d >> 1) - half_t'(1);
  endfunction
endpackage

// File: rtl/sclk_div_ctrl.sv
module sclk_div_ctrl
  import sclk_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              run_o,
  output logic              irq_en_o,
  output code_t             act_code_o
);
  logic [CTRL_W-1:0] word_q;
  code_t             act_code_q;

  // The active code may only move while the clock is stopped.
  logic  wr_while_idle;
  code_t wr_code;
  assign wr_while_idle = wr_en && !word_q[EN_BIT];
  assign wr_code       = wr_data[CODE_LSB +: CODE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q     <= '0;
      act_code_q <= '0;
    end else begin
      if (wr_en) word_q <= wr_data & CTRL_MASK;
      if (wr_while_idle)
        act_code_q <= wr_code;
      else if (!word_q[EN_BIT])
        act_code_q <= word_q[CODE_LSB +: CODE_W];
    end
  end

  assign rd_data    = word_q;
  assign run_o      = word_q[EN_BIT];
  assign irq_en_o   = word_q[IRQ_BIT];
  assign act_code_o = act_code_q;

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (rd_data == '0 && !run_o)); // R1
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_o) |-> $stable(act_code_o)); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~CTRL_MASK) == '0); // R2
endmodule

// File: rtl/sclk_div_lut.sv
module sclk_div_lut
  import sclk_div_pkg::*;
(
  input  code_t code_i,
  output half_t half_m1_o
);
  half_t rom [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_rom
    assign rom[g] = half_minus_one(code_to_div(code_t'(g)));
  end

  assign half_m1_o = rom[code_i];
endmodule

// File: rtl/sclk_div_count.sv
module sclk_div_count
  import sclk_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_i,
  input  half_t half_m1_i,
  output logic  sclk_o
);
  half_t cnt_q;
  logic  sclk_q;
  logic  running_q;

  logic start_evt;
  logic wrap_evt;
  assign start_evt = run_i && !running_q;
  assign wrap_evt  = run_i && running_q && (cnt_q == half_m1_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sclk_q    <= 1'b0;
      running_q <= 1'b0;
    end else begin
      running_q <= run_i;
      if (!run_i) begin
        cnt_q  <= '0;
        sclk_q <= 1'b0;
      end else if (start_evt) begin
        cnt_q  <= '0;
        sclk_q <= 1'b1;
      end else if (wrap_evt) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q  <= cnt_q + half_t'(1);
      end
    end
  end

  assign sclk_o = sclk_q;

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!sclk_o && cnt_q == '0)); // R6
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (sclk_o && cnt_q == '0)); // R7
  AST_TOGGLE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (sclk_o != $past(sclk_o))); // R5
  AST_STEADY_MIDPHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && running_q && !wrap_evt) |=> $stable(sclk_o)); // R5
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> cnt_q <= half_m1_i); // R3
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclk_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              irq_en_o,
  output logic              sclk_o
);
  logic  run;
  code_t act_code;
  half_t half_m1;

  sclk_div_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .run_o      (run),
    .irq_en_o   (irq_en_o),
    .act_code_o (act_code)
  );

  sclk_div_lut u_lut (
    .code_i    (act_code),
    .half_m1_o (half_m1)
  );

  sclk_div_count u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .half_m1_i (half_m1),
    .sclk_o    (sclk_o)
  );

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_o == rd_data[IRQ_BIT]); // R9
endmodule

// File: tb/sclk_divider_test.sv
module sclk_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_en_o;
  logic        sclk_o;

  always #4 clk = ~clk;

  sclk_divider uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_en_o(irq_en_o), .sclk_o(sclk_o)
  );

  // Stimulus: code is the index, entry is the expected divisor.
  localparam int EXP_DIV [16] = '{4, 6, 8, 10, 12, 16, 18, 20, 24, 32, 40, 50, 64, 128, 128, 128};

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input bit en, input int code, input bit irq);
    return (32'(irq) << 6) | (32'(code & 15) << 1) | 32'(en);
  endfunction

  task automatic write_ctrl(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    while (sclk_o && hi < 400) begin hi++; @(negedge clk); end
    while (!sclk_o && lo < 400) begin lo++; @(negedge clk); end
  endtask

  task automatic resync();
    int guard = 0;
    while (sclk_o && guard < 400) begin guard++; @(negedge clk); end
    while (!sclk_o && guard < 800) begin guard++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi, lo, low_seen;
    repeat (4) @(negedge clk);
    check(rd_data == 32'd0, "R1 readback", int'(rd_data), 0);
    check(!sclk_o, "R1 sclk", int'(sclk_o), 0);
    check(!irq_en_o, "R1 irq", int'(irq_en_o), 0);
    rst_n = 1'b1;

    // Vector walk over every code (R3 for 0..13, R4 for 14..15).
    for (int c = 0; c < 16; c++) begin
      write_ctrl(word(0, c, 0));
      @(negedge clk);
      check(!sclk_o, "R6 stopped", int'(sclk_o), 0);
      write_ctrl(word(1, c, 1));
      check(rd_data == word(1, c, 1), "R2 readback", int'(rd_data), int'(word(1, c, 1)));
      check(irq_en_o, "R9 irq set", int'(irq_en_o), 1);
      check(!sclk_o, "R7 latency low", int'(sclk_o), 0);
      @(negedge clk);
      check(sclk_o, "R7 rise", int'(sclk_o), 1);
      measure(hi, lo);
      check(hi == EXP_DIV[c] / 2, (c < 14) ? "R3 high phase" : "R4 high phase", hi, EXP_DIV[c] / 2);
      check(lo == EXP_DIV[c] / 2, "R5 low phase", lo, EXP_DIV[c] / 2);
    end

    // R8: code written while running is ignored by the clock.
    write_ctrl(word(0, 0, 0));
    write_ctrl(word(1, 0, 0));
    check(!irq_en_o, "R9 irq clear", int'(irq_en_o), 0);
    @(negedge clk);
    write_ctrl(word(1, 13, 0));
    check(rd_data == word(1, 13, 0), "R8 readback", int'(rd_data), int'(word(1, 13, 0)));
    resync();
    measure(hi, lo);
    check(hi == 2, "R8 high unchanged", hi, 2);
    check(lo == 2, "R8 low unchanged", lo, 2);

    // R6: held low while disabled.
    write_ctrl(word(0, 13, 0));
    @(negedge clk);
    low_seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (!sclk_o) low_seen++;
      @(negedge clk);
    end
    check(low_seen == 20, "R6 held low", low_seen, 20);

    // R10: disable/update/enable sequence takes the new code.
    write_ctrl(word(1, 13, 1));
    check(!sclk_o, "R10 latency low", int'(sclk_o), 0);
    @(negedge clk);
    check(sclk_o, "R10 rise", int'(sclk_o), 1);
    measure(hi, lo);
    check(hi == 64, "R10 high", hi, 64);
    check(lo == 64, "R10 low", lo, 64);

    // R2: undefined bits read as zero.
    write_ctrl(word(0, 0, 0));
    write_ctrl(32'hFFFF_FFFF);
    check(rd_data == 32'h0000_005F, "R2 mask", int'(rd_data), 32'h5F);
    repeat (10) @(negedge clk);

    // R1: reset mid-run.
    rst_n = 1'b0;
    @(negedge clk);
    check(rd_data == 32'd0, "R1 mid-run readback", int'(rd_data), 0);
    check(!sclk_o, "R1 mid-run sclk", int'(sclk_o), 0);
    check(!irq_en_o, "R1 mid-run irq", int'(irq_en_o), 0);
    rst_n = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule